// File: doc/BRIEF.md
# Dual-Mode SPI Byte Controller

This block moves one byte at a time over a four-wire serial link. A controller writes a byte into the data register, and that write starts the exchange. As master the block makes the serial clock itself from the system clock and shifts the byte out on MOSI while collecting a byte from MISO. As slave it follows a clock and an active-low select that come from outside. It drives MISO and collects from MOSI. Both clock polarities and both clock phases are supported.

When the byte finishes, the received value is copied into the data register and a sticky completion flag is set. An interrupt line follows that flag while interrupts are enabled. A slave using the first clock phase does not finish on its eighth clock edge. It finishes only when the external master releases select. Slave clock, select and data inputs cross into the system clock domain through two-stage synchronizers before any edge is detected.

Top module: `spi_byte_ctrl`

## Requirements
- R1: After reset, rd_data is 0x00, done_flag and irq are 0, and sclk_o rests at the level given by cfg_cpol.
- R2: A write (wr_stb high for one cycle) loads wr_data as the byte to send and starts a transfer. rd_data keeps its previous value through the transfer and changes only when the byte completes, to the received byte.
- R3: In master mode one write yields exactly 8 clock periods (16 edges) on sclk_o. No further edges follow, and sclk_o returns to the cfg_cpol level.
- R4: Bits are sent and received most significant bit first. The first serial bit is bit 7 and the last is bit 0.
- R5: In master mode each half period of sclk_o lasts 2^cfg_rate system clocks. Codes 0, 1, 2 and 3 therefore divide the system clock by 2, 4, 8 and 16.
- R6: In master mode ss_n_i has no effect on the transfer.
- R7: In slave mode, sclk_i edges count only while ss_n_i is low and a write has armed the block. Edges with select high, or with no write pending, change neither rd_data nor done_flag.
- R8: A slave with cfg_cpha=1 completes on the eighth received sampling edge. A slave with cfg_cpha=0 holds off completion after its eighth edge and completes only when ss_n_i rises.
- R9: Completion sets done_flag, which stays set until a flag_clr pulse clears it. irq is high exactly while done_flag and cfg_irq_en are both high.
- R10: With cfg_cpha=0 the first bit is on the data line before the first edge, and data is sampled on leading edges and changed on trailing edges. With cfg_cpha=1 data changes on leading edges and is sampled on trailing edges. A leading edge is the transition away from the cfg_cpol level.
- R11: A write that arrives while a transfer is in progress is ignored. The byte in flight and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_master | input | 1 | 1 selects master, 0 selects slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges |
| cfg_rate | input | RATE_W | Master clock divider code, half period 2^code system clocks |
| cfg_irq_en | input | 1 | Lets done_flag reach irq |
| wr_stb | input | 1 | One-cycle write strobe for the data register |
| wr_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Last completely received byte |
| flag_clr | input | 1 | One-cycle pulse that clears done_flag |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Master data out (low in slave mode) |
| miso_i | input | 1 | Master data in |
| sclk_i | input | 1 | Serial clock from an external master |
| ss_n_i | input | 1 | Active-low select from an external master |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out (low in slave master mode is low) |

## Verification
The bench builds the block with its defaults: 8-bit bytes and a 2-bit rate code. With these, every divider setting from 2 to 16 can be driven. The fastest setting puts a sampling edge and a shifting edge in back-to-back system cycles, which tests the separation of the sample and drive events under the tightest timing. In slave mode the bench holds each external clock phase for six system clocks. That covers the synchronizer delay while keeping the transfers short enough to cover all four polarity and phase pairs, both completion rules, and the select and arming cases.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // What a qualified serial clock edge asks the shifter to do.
  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,
    EV_SAMPLE = 2'd1,
    EV_DRIVE  = 2'd2
  } shift_ev_e;
endpackage

// File: rtl/sbc_sync.sv
module sbc_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/sbc_clkgen.sv
module sbc_clkgen #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate,
  output logic              tick,
  output logic              lead,
  output logic              last,
  output logic              phase
);
  localparam int unsigned DIV_W = (1 << RATE_W) - 1;
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned EW    = $clog2(EDGES);

  logic [DIV_W-1:0] div_q, div_d, half_m1;
  logic [EW-1:0]    edge_q, edge_d;
  logic             active_q, active_d, phase_q, phase_d;

  always_comb begin
    half_m1 = DIV_W'((32'd1 << rate) - 32'd1);
    tick    = active_q && (div_q == half_m1);
    lead    = ~edge_q[0];
    last    = tick && (edge_q == EW'(EDGES - 1));
  end

  always_comb begin
    div_d    = div_q;
    edge_d   = edge_q;
    active_d = active_q;
    phase_d  = phase_q;
    if (start) begin
      div_d    = '0;
      edge_d   = '0;
      active_d = 1'b1;
      phase_d  = 1'b0;
    end else if (active_q) begin
      if (tick) begin
        div_d   = '0;
        edge_d  = edge_q + 1'b1;
        phase_d = ~phase_q;
        if (last) active_d = 1'b0;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      edge_q   <= '0;
      active_q <= 1'b0;
      phase_q  <= 1'b0;
    end else begin
      div_q    <= div_d;
      edge_q   <= edge_d;
      active_q <= active_d;
      phase_q  <= phase_d;
    end
  end

  assign phase = phase_q;

  // An even number of toggles must bring the clock back to idle.
  assert_idle_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !phase_q);
endmodule

// File: rtl/sbc_shifter.sv
module sbc_shifter
  import sbc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  shift_ev_e         ev,
  input  logic              in_bit,
  output logic              out_bit,
  output logic [DATA_W-1:0] rx,
  output logic [CW-1:0]     bit_cnt
);
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    cnt_d = cnt_q;
    if (load) begin
      tx_d  = load_data;
      cnt_d = '0;
    end else begin
      unique case (ev)
        EV_SAMPLE: begin
          rx_d  = {rx_q[DATA_W-2:0], in_bit};
          cnt_d = cnt_q + 1'b1;
        end
        EV_DRIVE: begin
          // The first drive edge of phase 1 presents the MSB already loaded.
          if (cnt_q != '0) tx_d = {tx_q[DATA_W-2:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      cnt_q <= cnt_d;
    end
  end

  assign out_bit = tx_q[DATA_W-1];
  assign rx      = rx_q;
  assign bit_cnt = cnt_q;

  assert_bitcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DATA_W));
endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_irq_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flag_clr,
  output logic              done_flag,
  output logic              irq,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sclk_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o
);
  localparam int unsigned CW = $clog2(DATA_W + 1);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_sr_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_int_n = rst_sr_q[1];

  // Slave-side inputs enter the system domain.
  logic sclk_s, ss_s, mosi_s, sclk_p_q, ss_p_q;
  sbc_sync #(.W(3), .RST_VAL(3'b010)) i_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({mosi_i, ss_n_i, sclk_i}), .q({mosi_s, ss_s, sclk_s})
  );

  logic busy_q, busy_d, complete_q, complete_d, flag_q, flag_d;
  logic [DATA_W-1:0] dreg_q, dreg_d;
  logic start, m_tick, m_lead, m_last, m_phase;
  logic s_edge, s_lead, ss_rise, ev_valid, ev_lead, in_bit, out_bit;
  logic [DATA_W-1:0] rx;
  logic [CW-1:0] bit_cnt;
  shift_ev_e ev;

  assign start = wr_stb && !busy_q;

  sbc_clkgen #(.DATA_W(DATA_W), .RATE_W(RATE_W)) i_clkgen (
    .clk(clk), .rst_n(rst_int_n), .start(start && cfg_master), .rate(cfg_rate),
    .tick(m_tick), .lead(m_lead), .last(m_last), .phase(m_phase)
  );

  always_comb begin
    s_edge   = (sclk_s != sclk_p_q) && !ss_s && busy_q && !cfg_master;
    s_lead   = (sclk_s != cfg_cpol);
    ss_rise  = ss_s && !ss_p_q;
    ev_valid = cfg_master ? m_tick : s_edge;
    ev_lead  = cfg_master ? m_lead : s_lead;
    if (!ev_valid)                ev = EV_IDLE;
    else if (ev_lead ^ cfg_cpha)  ev = EV_SAMPLE;
    else                          ev = EV_DRIVE;
    in_bit = cfg_master ? miso_i : mosi_s;
  end

  sbc_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk(clk), .rst_n(rst_int_n), .load(start), .load_data(wr_data),
    .ev(ev), .in_bit(in_bit), .out_bit(out_bit), .rx(rx), .bit_cnt(bit_cnt)
  );

  always_comb begin
    if (cfg_master)    complete_d = m_last;
    else if (cfg_cpha) complete_d = (ev == EV_SAMPLE) && (bit_cnt == CW'(DATA_W - 1));
    else               complete_d = ss_rise && (bit_cnt == CW'(DATA_W));
    complete_d = complete_d && busy_q && !complete_q;

    busy_d = busy_q;
    if (complete_q) busy_d = 1'b0;
    else if (start) busy_d = 1'b1;

    flag_d = flag_q;
    if (complete_q)    flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;

    dreg_d = complete_q ? rx : dreg_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q     <= 1'b0;
      complete_q <= 1'b0;
      flag_q     <= 1'b0;
      dreg_q     <= '0;
      sclk_p_q   <= 1'b0;
      ss_p_q     <= 1'b1;
    end else begin
      busy_q     <= busy_d;
      complete_q <= complete_d;
      flag_q     <= flag_d;
      dreg_q     <= dreg_d;
      sclk_p_q   <= sclk_s;
      ss_p_q     <= ss_s;
    end
  end

  assign rd_data   = dreg_q;
  assign done_flag = flag_q;
  assign irq       = flag_q && cfg_irq_en;
  assign sclk_o    = cfg_cpol ^ m_phase;
  assign mosi_o    = cfg_master && out_bit;
  assign miso_o    = !cfg_master && out_bit;

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_q && !flag_clr) |=> flag_q);

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_q && !complete_q) |=> $stable(rd_data));

  assert_slave_full_byte_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (complete_q && !cfg_master) |-> (bit_cnt == CW'(DATA_W)));

  assert_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_q && wr_stb && !complete_q) |=> busy_q);

  assert_master_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_master && !busy_q) |-> (sclk_o == cfg_cpol));
endmodule

// File: tb/test_spi_byte_ctrl.sv
`timescale 1ns/1ps
module test_spi_byte_ctrl;
  localparam int W  = 8;
  localparam int RW = 2;
  localparam int H  = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_master, cfg_cpol, cfg_cpha, cfg_irq_en, wr_stb, flag_clr;
  logic [RW-1:0] cfg_rate;
  logic [W-1:0] wr_data, rd_data;
  logic done_flag, irq, sclk_o, mosi_o, miso_i, sclk_i, ss_n_i, mosi_i, miso_o;

  spi_byte_ctrl #(.DATA_W(W), .RATE_W(RW)) i_spi_byte_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .cfg_irq_en(cfg_irq_en),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .flag_clr(flag_clr),
    .done_flag(done_flag), .irq(irq), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  typedef struct { logic [W-1:0] rx; logic [W-1:0] tx; } exp_t;
  exp_t sb_q[$];
  exp_t mon_e;
  logic [W-1:0] cap = '0;
  logic [W-1:0] last_rx = '0;
  logic done_prev = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // Monitor: compares each completed byte against the scoreboard.
  always @(negedge clk) begin
    if (done_flag && !done_prev) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9", "completion with nothing expected", 1, 0);
      end else begin
        mon_e = sb_q.pop_front();
        check(rd_data == mon_e.rx, "R4", "received byte", int'(rd_data), int'(mon_e.rx));
        check(cap == mon_e.tx, "R10", "sent byte seen on the line", int'(cap), int'(mon_e.tx));
      end
    end
    done_prev = done_flag;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [W-1:0] d);
    @(negedge clk); wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    tick(1);
    check(done_flag == 1'b0, "R9", "flag after clear", int'(done_flag), 0);
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done_flag && t < 2000) begin @(negedge clk); t++; end
    check(done_flag == 1'b1, req, "completion flag", int'(done_flag), 1);
    tick(5);
    check(done_flag == 1'b1, "R9", "flag stays set", int'(done_flag), 1);
    check(irq == cfg_irq_en, "R9", "irq follows flag and enable", int'(irq), int'(cfg_irq_en));
  endtask

  // Bench acts as the external slave while the design is master.
  task automatic master_xfer(input logic cpol, input logic cpha, input logic [RW-1:0] rate,
                             input logic [W-1:0] tx, input logic [W-1:0] peer,
                             input logic ss, input bit mid_wr);
    exp_t e;
    logic [W-1:0] sh;
    logic prev;
    int edges = 0, bad = 0, gap = 0, t = 0, extra = 0;
    cfg_master = 1'b1; cfg_cpol = cpol; cfg_cpha = cpha; cfg_rate = rate; ss_n_i = ss;
    tick(3);
    check(sclk_o == cpol, "R3", "idle clock level", int'(sclk_o), int'(cpol));
    sh = peer; miso_i = peer[W-1]; cap = '0; prev = cpol;
    e.rx = peer; e.tx = tx; sb_q.push_back(e);
    write_byte(tx);
    check(rd_data == last_rx, "R2", "data register after write", int'(rd_data), int'(last_rx));
    while (edges < 2*W && t < 1000) begin
      @(negedge clk); t++; gap++;
      if (mid_wr && t == 5) begin wr_data = ~tx; wr_stb = 1'b1; end
      else wr_stb = 1'b0;
      if (sclk_o != prev) begin
        if (edges > 0 && gap != (1 << rate)) bad++;
        gap = 0; prev = sclk_o; edges++;
        if ((sclk_o != cpol) ^ cpha) begin
          cap = {cap[W-2:0], mosi_o};
          sh = {sh[W-2:0], 1'b0};
          miso_i = sh[W-1];
        end
      end
    end
    wr_stb = 1'b0;
    check(edges == 2*W, "R3", "clock edges per write", edges, 2*W);
    check(bad == 0, "R5", "half periods off the divider", bad, 0);
    wait_done(ss ? "R2" : "R6");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk_o != prev) begin extra++; prev = sclk_o; end
    end
    check(extra == 0, "R3", "edges after the burst", extra, 0);
    check(sclk_o == cpol, "R3", "clock level after burst", int'(sclk_o), int'(cpol));
    if (mid_wr) check(rd_data == peer, "R11", "result with a write mid-transfer", int'(rd_data), int'(peer));
    last_rx = peer;
    clear_flag();
  endtask

  // Bench acts as the external master while the design is slave.
  task automatic slave_xfer(input logic cpol, input logic cpha, input logic [W-1:0] tx,
                            input logic [W-1:0] peer, input int pre);
    exp_t e;
    cfg_master = 1'b0; cfg_cpol = cpol; cfg_cpha = cpha;
    sclk_i = cpol; ss_n_i = 1'b1; mosi_i = 1'b0;
    tick(8);
    e.rx = peer; e.tx = tx; sb_q.push_back(e);
    cap = '0;
    write_byte(tx);
    for (int p = 0; p < pre; p++) begin tick(H); sclk_i = ~sclk_i; end
    tick(H);
    if (pre > 0) check(done_flag == 1'b0, "R7", "flag after clocks with select high", int'(done_flag), 0);
    ss_n_i = 1'b0;
    tick(H);
    for (int i = W-1; i >= 0; i--) begin
      if (!cpha) begin
        mosi_i = peer[i]; tick(H);
        cap = {cap[W-2:0], miso_o}; sclk_i = ~sclk_i; tick(H);
        sclk_i = ~sclk_i;
      end else begin
        sclk_i = ~sclk_i; mosi_i = peer[i]; tick(H);
        cap = {cap[W-2:0], miso_o}; sclk_i = ~sclk_i; tick(H);
      end
      if (i == 3) check(rd_data == last_rx, "R2", "data register mid-transfer", int'(rd_data), int'(last_rx));
    end
    tick(10);
    if (!cpha) check(done_flag == 1'b0, "R8", "phase 0 waits for select", int'(done_flag), 0);
    else       check(done_flag == 1'b1, "R8", "phase 1 done at eighth edge", int'(done_flag), 1);
    ss_n_i = 1'b1;
    wait_done("R8");
    last_rx = peer;
    clear_flag();
  endtask

  initial begin
    rst_n = 1'b0; cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_rate = '0;
    cfg_irq_en = 1'b0; wr_stb = 1'b0; wr_data = '0; flag_clr = 1'b0;
    miso_i = 1'b0; sclk_i = 1'b0; ss_n_i = 1'b1; mosi_i = 1'b0;
    tick(3); rst_n = 1'b1; tick(4);
    check(rd_data == '0, "R1", "data register after reset", int'(rd_data), 0);
    check(done_flag == 1'b0, "R1", "flag after reset", int'(done_flag), 0);
    check(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
    check(sclk_o == 1'b0, "R1", "clock level after reset", int'(sclk_o), 0);

    master_xfer(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 1'b1, 0);
    master_xfer(1'b0, 1'b1, 2'd1, 8'h96, 8'hC3, 1'b1, 0);
    master_xfer(1'b1, 1'b0, 2'd2, 8'h0F, 8'hF0, 1'b0, 0);
    cfg_irq_en = 1'b1;
    master_xfer(1'b1, 1'b1, 2'd3, 8'h81, 8'h7E, 1'b1, 0);
    master_xfer(1'b0, 1'b0, 2'd1, 8'h5A, 8'hA5, 1'b1, 1);
    cfg_irq_en = 1'b0;

    slave_xfer(1'b0, 1'b0, 8'hC6, 8'h39, 0);
    slave_xfer(1'b0, 1'b1, 8'h1E, 8'hE1, 0);
    slave_xfer(1'b1, 1'b0, 8'hB4, 8'h4B, 4);
    slave_xfer(1'b1, 1'b1, 8'h01, 8'h80, 2);

    // R7: select low but no write pending, so the edges must count for nothing.
    cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; sclk_i = 1'b0; tick(8);
    ss_n_i = 1'b0; tick(H);
    for (int i = 0; i < 2*W; i++) begin mosi_i = i[0]; sclk_i = ~sclk_i; tick(H); end
    ss_n_i = 1'b1; tick(12);
    check(done_flag == 1'b0, "R7", "flag without an armed write", int'(done_flag), 0);
    check(rd_data == last_rx, "R7", "data register without an armed write", int'(rd_data), int'(last_rx));
    check(sb_q.size() == 0, "R9", "completions still outstanding", sb_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule